// File: doc/BRIEF.md
# Cascadable Decimal Up/Down Counter Digit

This block is one synchronous counting digit that moves through the values 0 to 9. On every rising clock edge it does exactly one of four things. It clears, takes a parallel preset value, keeps its value, or steps one place. A direction input sets whether the step goes up or down.

Two outputs let several digits be joined into a multi-digit decimal counter. A terminal flag reports that the digit sits at the last value for the current direction. An active-low carry reports that the digit will roll over on the next enabled edge. To chain digits, every digit shares the clock, preset and direction lines, and each digit's active-low enable is driven from the carry of the digit below it.

The modulus and the code width are parameters, so the same block can serve as a plain binary counter stage. The defaults give a decimal digit coded in 4 bits.

Top module: `dcd_digit`

## Requirements
- R1: With the enable `step_en_n` low, `preset_n` high and `dir_dn` = 0, each rising edge moves `digit` up by one: 0,1,...,9, and then 9 wraps to 0. Codes 10 to 15 are never produced by a step.
- R2: `dir_dn` = 1 selects decrement and `dir_dn` = 0 selects increment.
- R3: With `step_en_n` high and `preset_n` high, `digit` keeps its value across rising edges.
- R4: With `preset_n` low, `preset_val` appears on `digit` after the next rising edge, whatever `step_en_n` and `dir_dn` are.
- R5: `carry_n` is 0 exactly when `term` is 1 and `step_en_n` is 0; otherwise it is 1.
- R6: Counting down, 0 wraps to 9 on an enabled edge.
- R7: `term` is 1 exactly when `digit` equals 9 with `dir_dn` = 0, or equals 0 with `dir_dn` = 1. This holds whatever the enable is.
- R8: If a preset leaves an illegal code (10 to 15) in `digit`, the next enabled step gives 0 when counting up and 9 when counting down.
- R9: `rst` high at a rising edge clears `digit` to 0. Reset takes priority over preset and over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| preset_n | input | 1 | Parallel preset, active low |
| preset_val | input | 4 | Value taken by a preset |
| dir_dn | input | 1 | 1 = count down, 0 = count up |
| step_en_n | input | 1 | Count enable, active low |
| digit | output | 4 | Current count value |
| carry_n | output | 1 | Active-low rollover indication for the next digit |
| term | output | 1 | Digit is at the terminal value for the direction |

## Verification
The bench runs several kinds of input sequence:

- A long enabled run upward, which exposes a wrong wrap point or any escape into codes 10 to 15.
- A long enabled run downward, which exposes a missing borrow from 0.
- Held intervals parked at 9 and at 0. These separate the enable-independent terminal flag from the enable-gated carry.
- Presets of the illegal codes 12 and 15 followed by one step each way. These show the recovery value.
- Reset asserted together with preset and count, and presets made with the enable both active and inactive. These expose any wrong priority.
- A long random mix of all inputs, compared on every clock.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_STEP  = 2'd2,
      OP_CLEAR = 2'd3
   } dcd_op_e;
endpackage

// File: rtl/dcd_ctrl.sv
module dcd_ctrl
   import dcd_pkg::*;
(
   input  logic    rst,
   input  logic    preset_n,
   input  logic    step_en_n,
   output dcd_op_e op
);
   always_comb begin
      if (rst)             op = OP_CLEAR;
      else if (!preset_n)  op = OP_LOAD;
      else if (!step_en_n) op = OP_STEP;
      else                 op = OP_HOLD;
   end
endmodule

// File: rtl/dcd_next.sv
module dcd_next
   import dcd_pkg::*;
#(
   parameter int W       = 4,
   parameter int MODULUS = 10
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] preset_val,
   input  logic         dir_dn,
   input  dcd_op_e      op,
   output logic [W-1:0] nxt
);
   localparam logic [W-1:0] LAST  = W'(MODULUS - 1);
   localparam logic [W:0]   MOD_V = (W+1)'(MODULUS);

   logic [W-1:0] up_v;
   logic [W-1:0] dn_v;

   generate
      if (MODULUS == (1 << W)) begin : g_full
         // every code is legal: natural wrap of the adder
         assign up_v = cur + 1'b1;
         assign dn_v = cur - 1'b1;
      end else begin : g_partial
         logic bad;
         assign bad  = ({1'b0, cur} >= MOD_V);
         assign up_v = (bad || cur == LAST) ? '0 : cur + 1'b1;
         assign dn_v = (bad || cur == '0) ? LAST : cur - 1'b1;
      end
   endgenerate

   always_comb begin
      unique case (op)
         OP_CLEAR: nxt = '0;
         OP_LOAD:  nxt = preset_val;
         OP_STEP:  nxt = dir_dn ? dn_v : up_v;
         default:  nxt = cur;
      endcase
   end
endmodule

// File: rtl/dcd_term.sv
module dcd_term #(
   parameter int W       = 4,
   parameter int MODULUS = 10
) (
   input  logic [W-1:0] cur,
   input  logic         dir_dn,
   input  logic         step_en_n,
   output logic         term,
   output logic         carry_n
);
   localparam logic [W-1:0] LAST = W'(MODULUS - 1);

   logic at_top;
   logic at_bot;
   assign at_top  = (cur == LAST);
   assign at_bot  = (cur == '0);
   assign term    = dir_dn ? at_bot : at_top;
   assign carry_n = ~(term & ~step_en_n);
endmodule

// File: rtl/dcd_digit.sv
module dcd_digit
   import dcd_pkg::*;
#(
   parameter int W       = 4,
   parameter int MODULUS = 10
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         preset_n,
   input  logic [W-1:0] preset_val,
   input  logic         dir_dn,
   input  logic         step_en_n,
   output logic [W-1:0] digit,
   output logic         carry_n,
   output logic         term
);
   localparam logic [W-1:0] LAST  = W'(MODULUS - 1);
   localparam logic [W:0]   MOD_V = (W+1)'(MODULUS);

   generate
      if (W < 1 || W > 16) begin : g_bad_w
         $error("dcd_digit: W out of range");
      end
      if (MODULUS < 2 || MODULUS > (1 << W)) begin : g_bad_mod
         $error("dcd_digit: MODULUS must lie in 2 .. 2**W");
      end
   endgenerate

   dcd_op_e      op;
   logic [W-1:0] nxt;
   logic [W-1:0] cnt_q;

   dcd_ctrl u_ctrl (
      .rst       (rst),
      .preset_n  (preset_n),
      .step_en_n (step_en_n),
      .op        (op)
   );

   dcd_next #(.W(W), .MODULUS(MODULUS)) u_next (
      .cur        (cnt_q),
      .preset_val (preset_val),
      .dir_dn     (dir_dn),
      .op         (op),
      .nxt        (nxt)
   );

   dcd_term #(.W(W), .MODULUS(MODULUS)) u_term (
      .cur       (cnt_q),
      .dir_dn    (dir_dn),
      .step_en_n (step_en_n),
      .term      (term),
      .carry_n   (carry_n)
   );

   always_ff @(posedge clk) begin
      cnt_q <= nxt;
   end

   assign digit = cnt_q;

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> digit == '0); // R9
   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
      !preset_n |=> digit == $past(preset_val)); // R4
   AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
      (preset_n && step_en_n) |=> $stable(digit)); // R3
   AST_UP_WRAP: assert property (@(posedge clk) disable iff (rst)
      (preset_n && !step_en_n && !dir_dn && digit == LAST) |=> digit == '0); // R1
   AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (rst)
      (preset_n && !step_en_n && dir_dn && digit == '0) |=> digit == LAST); // R6
   AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (rst)
      (preset_n && !step_en_n) |=> ({1'b0, digit} < MOD_V)); // R8
   AST_CARRY_AT_END: assert property (@(posedge clk) disable iff (rst)
      !carry_n |-> ((digit == LAST && !dir_dn) || (digit == '0 && dir_dn))); // R5
   AST_NO_CARRY_IDLE: assert property (@(posedge clk) disable iff (rst)
      step_en_n |-> carry_n); // R5
endmodule

// File: tb/sim_dcd_digit.sv
module sim_dcd_digit;
   localparam int PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       preset_n = 1'b1;
   logic [3:0] preset_val = 4'd0;
   logic       dir_dn = 1'b0;
   logic       step_en_n = 1'b1;
   logic [3:0] digit;
   logic       carry_n;
   logic       term;

   int vectors = 0;
   int errors  = 0;
   int model   = 0;

   always #(PERIOD/2) clk = ~clk;

   dcd_digit u0 (
      .clk(clk), .rst(rst), .preset_n(preset_n), .preset_val(preset_val),
      .dir_dn(dir_dn), .step_en_n(step_en_n),
      .digit(digit), .carry_n(carry_n), .term(term)
   );

   // reference model update, behavioural, applied at each rising edge
   always @(posedge clk) begin
      if (rst)             model <= 0;
      else if (!preset_n)  model <= int'(preset_val);
      else if (!step_en_n) begin
         if (dir_dn) model <= (model == 0 || model > 9) ? 9 : model - 1;
         else        model <= (model >= 9) ? 0 : model + 1;
      end
   end

   task automatic compare(input string tag);
      bit exp_term;
      bit exp_carry_n;
      exp_term    = (!dir_dn && model == 9) || (dir_dn && model == 0);
      exp_carry_n = !(exp_term && !step_en_n);
      vectors++;
      if (int'(digit) != model || term != exp_term || carry_n != exp_carry_n) begin
         errors++;
         $display("FAIL %s: digit=%0d term=%0b carry_n=%0b expected digit=%0d term=%0b carry_n=%0b",
                  tag, digit, term, carry_n, model, exp_term, exp_carry_n);
      end
   endtask

   // one clock: drive at falling edge, check outputs of current state
   task automatic cyc(input bit r, input bit ld_n, input int dv, input bit dn,
                      input bit en_n, input string tag);
      @(negedge clk);
      rst = r; preset_n = ld_n; preset_val = 4'(dv); dir_dn = dn; step_en_n = en_n;
      #1 compare(tag);
   endtask

   initial begin
      #(PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      // R9: reset state
      cyc(1, 1, 0, 0, 1, "R9");
      cyc(1, 1, 0, 0, 1, "R9");
      // R1 / R5 / R7: count up through the wrap
      for (int i = 0; i < 13; i++) cyc(0, 1, 0, 0, 0, "R1");
      // R3 / R7: load 9, hold with enable off, term high, carry high
      cyc(0, 0, 9, 0, 1, "R4");
      for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 1, "R3");
      cyc(0, 1, 0, 0, 1, "R7");
      cyc(0, 1, 0, 0, 0, "R5");
      // R2 / R6: count down through the wrap
      for (int i = 0; i < 13; i++) cyc(0, 1, 0, 1, 0, "R6");
      cyc(0, 1, 0, 1, 1, "R2");
      // R4: preset with enable active and inactive, both directions
      cyc(0, 0, 5, 0, 0, "R4");
      cyc(0, 0, 3, 1, 1, "R4");
      cyc(0, 1, 0, 1, 1, "R4");
      cyc(0, 0, 0, 1, 1, "R7");
      cyc(0, 1, 0, 1, 1, "R7");
      cyc(0, 1, 0, 0, 1, "R7");
      // R8: illegal codes recover
      cyc(0, 0, 12, 0, 1, "R8");
      cyc(0, 1, 0, 0, 0, "R8");
      cyc(0, 1, 0, 0, 1, "R8");
      cyc(0, 0, 15, 1, 1, "R8");
      cyc(0, 1, 0, 1, 0, "R8");
      cyc(0, 1, 0, 1, 1, "R8");
      // R9: reset beats preset and count
      cyc(0, 0, 6, 0, 1, "R9");
      cyc(1, 0, 7, 0, 0, "R9");
      cyc(1, 1, 0, 1, 0, "R9");
      cyc(0, 1, 0, 1, 1, "R9");
      // mixed random traffic
      for (int i = 0; i < 600; i++)
         cyc(($urandom % 40) == 0, ($urandom % 8) != 0, int'($urandom % 16),
             $urandom % 2, ($urandom % 4) == 0, "R2");
      cyc(0, 1, 0, 0, 1, "R3");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule